// File: doc/BRIEF.md
# Flash Command Gating Controller

This block holds the control state that a serial flash device uses to decide whether an incoming command is acted on or dropped. It receives one decoded opcode per chip-select frame as a single-cycle strobe. For that opcode it raises either an accept flag or an ignore flag in the same cycle. It tracks the write-enable latch, the two-step software reset handshake, and the run, suspend-pending and suspended phases of an embedded program or erase operation. The serial shifter, the memory array and the analog timing are outside this block.

A loadable down-counter models the self-timed program and erase time. It holds a separate length for each operation class. It freezes while the operation is suspended and continues from the remaining count when the operation resumes. A parameter selects whether the alternate chip-erase opcode is decoded. The status outputs are the write-enable bit, the suspend bit and the busy bit. The block also drives a one-cycle reset pulse to the rest of the device.

Top module: `fcg_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `wel`, `sus`, `busy` and `rst_pulse` are all 0.
- R2: Opcode 06h is accepted whenever `busy` is 0, and `wel` reads 1 from the next cycle onward. While `busy` is 1, opcode 06h is ignored.
- R3: The write-class opcodes are accepted only when `wel`=1, `busy`=0 and `sus`=0. These opcodes are 02h (page program), 20h (sector erase), D8h (block erase), C7h and 60h (chip erase) and 01h (status write). A rejected write-class opcode leaves `wel`, `busy` and `sus` unchanged.
- R4: An accepted write-class opcode holds `busy` at 1 for exactly the configured number of cycles, starting in the cycle after acceptance. The lengths are PGM_CYCLES for page program, ERASE_CYCLES for sector or block erase, CHIP_CYCLES for chip erase and WRSR_CYCLES for status write. `wel` returns to 0 in the same cycle that `busy` falls.
- R5: While `busy` is 1, only four opcodes can be accepted: 05h (status read), 75h, 66h, and 99h when the reset is armed. Every other opcode is ignored. Opcode 05h is always accepted. For every strobe, exactly one of `op_accept` and `op_ignore` is 1.
- R6: Opcode 75h is ignored when `sus`=1, when `busy`=0, or when a suspend is already pending. Once 75h is accepted, the operation count freezes. `busy` stays 1 for SUSP_LAT more cycles, after which `busy` reads 0 and `sus` reads 1.
- R7: Opcode 7Ah is ignored when `sus`=0 or `busy`=1. Once it is accepted, `sus` clears, `busy` returns to 1, and `busy` stays 1 for the cycles that remained when the suspend was accepted.
- R8: When opcode 99h directly follows an accepted 66h, it is accepted. In the next cycle `rst_pulse` is 1 for exactly one cycle, and `wel`, `sus` and `busy` are 0.
- R9: Any opcode other than 66h that follows 66h cancels the arm. A 99h that arrives without the arm in place is ignored and produces no `rst_pulse`.
- R10: The interface mode switch opcodes 38h and FFh leave `wel` and `sus` unchanged.
- R11: `busy` and `sus` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | One-cycle strobe marking a decoded opcode |
| op_code | input | 8 | Decoded opcode value |
| op_accept | output | 1 | Strobed opcode is acted on |
| op_ignore | output | 1 | Strobed opcode is dropped |
| wel | output | 1 | Write-enable latch |
| sus | output | 1 | Operation suspended |
| busy | output | 1 | Program, erase or status write in progress |
| rst_pulse | output | 1 | One-cycle software reset pulse |

## Verification
The bench times the busy window cycle by cycle against each configured length. A counter that is off by one, or one that keeps running while suspended, would show a window that is too long or too short. The bench also sends a second 75h while the suspend is still pending. A design that accepted it would reload the latency and hold `busy` longer. It breaks the reset handshake with a status read placed between 66h and 99h. A design that kept the arm would fire a reset and wipe `wel`. Finally, it sends a write-class opcode with `wel` clear and again during a suspend. A design that gates on only one of these conditions would start a busy cycle.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
   localparam logic [7:0] OP_WREN   = 8'h06;
   localparam logic [7:0] OP_PP     = 8'h02;
   localparam logic [7:0] OP_SE     = 8'h20;
   localparam logic [7:0] OP_BE     = 8'hD8;
   localparam logic [7:0] OP_CE     = 8'hC7;
   localparam logic [7:0] OP_CE_ALT = 8'h60;
   localparam logic [7:0] OP_WRSR   = 8'h01;
   localparam logic [7:0] OP_RDSR   = 8'h05;
   localparam logic [7:0] OP_SUSP   = 8'h75;
   localparam logic [7:0] OP_RESUME = 8'h7A;
   localparam logic [7:0] OP_RSTEN  = 8'h66;
   localparam logic [7:0] OP_RST    = 8'h99;

   typedef enum logic [2:0] {
      CL_OTHER, CL_WREN, CL_WRITE, CL_STATUS,
      CL_SUSP, CL_RESUME, CL_RSTEN, CL_RST
   } cmd_cls_e;

   typedef enum logic [1:0] {L_PGM, L_ERASE, L_CHIP, L_WRSR} len_sel_e;

   typedef enum logic [1:0] {T_IDLE, T_RUN, T_PEND, T_SUSP} tmr_st_e;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/fcg_decode.sv
module fcg_decode
   import fcg_pkg::*;
#(
   parameter bit CHIP_ALT_EN = 1'b1
) (
   input  logic [7:0] code,
   output cmd_cls_e   cls,
   output len_sel_e   lsel
);
   logic alt_chip;

   generate
      if (CHIP_ALT_EN) begin : g_alt_on
         assign alt_chip = (code == OP_CE_ALT);
      end else begin : g_alt_off
         assign alt_chip = 1'b0;
      end
   endgenerate

   always_comb begin
      cls  = CL_OTHER;
      lsel = L_PGM;
      case (code)
         OP_WREN:   cls = CL_WREN;
         OP_PP:     begin cls = CL_WRITE; lsel = L_PGM;   end
         OP_SE:     begin cls = CL_WRITE; lsel = L_ERASE; end
         OP_BE:     begin cls = CL_WRITE; lsel = L_ERASE; end
         OP_CE:     begin cls = CL_WRITE; lsel = L_CHIP;  end
         OP_WRSR:   begin cls = CL_WRITE; lsel = L_WRSR;  end
         OP_RDSR:   cls = CL_STATUS;
         OP_SUSP:   cls = CL_SUSP;
         OP_RESUME: cls = CL_RESUME;
         OP_RSTEN:  cls = CL_RSTEN;
         OP_RST:    cls = CL_RST;
         default:   cls = CL_OTHER;
      endcase
      if (alt_chip) begin
         cls  = CL_WRITE;
         lsel = L_CHIP;
      end
   end
endmodule

// File: rtl/fcg_op_timer.sv
module fcg_op_timer
   import fcg_pkg::*;
#(
   parameter int PGM_CYCLES   = 40,
   parameter int ERASE_CYCLES = 120,
   parameter int CHIP_CYCLES  = 400,
   parameter int WRSR_CYCLES  = 25,
   parameter int SUSP_LAT     = 5
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  len_sel_e len_sel,
   input  logic     susp_req,
   input  logic     resume_req,
   input  logic     flush,
   output logic     busy,
   output logic     sus,
   output logic     can_susp,
   output logic     done
);
   localparam int MAX_LEN = max4(PGM_CYCLES, ERASE_CYCLES, CHIP_CYCLES, WRSR_CYCLES);
   localparam int CNT_W   = $clog2(MAX_LEN + 1);
   localparam int LAT_W   = $clog2(SUSP_LAT + 1);

   tmr_st_e          st_q;
   logic [CNT_W-1:0] rem_q;
   logic [LAT_W-1:0] lat_q;
   logic [CNT_W-1:0] len_val;

   always_comb begin
      case (len_sel)
         L_PGM:   len_val = CNT_W'(PGM_CYCLES);
         L_ERASE: len_val = CNT_W'(ERASE_CYCLES);
         L_CHIP:  len_val = CNT_W'(CHIP_CYCLES);
         default: len_val = CNT_W'(WRSR_CYCLES);
      endcase
   end

   assign busy     = (st_q == T_RUN) || (st_q == T_PEND);
   assign sus      = (st_q == T_SUSP);
   assign can_susp = (st_q == T_RUN);
   assign done     = (st_q == T_RUN) && !susp_req && (rem_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         st_q  <= T_IDLE;
         rem_q <= '0;
         lat_q <= '0;
      end else begin
         case (st_q)
            T_IDLE: if (start) begin
               rem_q <= len_val;
               st_q  <= T_RUN;
            end
            T_RUN: begin
               if (susp_req) begin
                  st_q  <= T_PEND;
                  lat_q <= LAT_W'(SUSP_LAT);
               end else if (rem_q == CNT_W'(1)) begin
                  st_q  <= T_IDLE;
                  rem_q <= '0;
               end else begin
                  rem_q <= rem_q - CNT_W'(1);
               end
            end
            T_PEND: begin
               if (lat_q == LAT_W'(1)) st_q <= T_SUSP;
               else lat_q <= lat_q - LAT_W'(1);
            end
            default: if (resume_req) st_q <= T_RUN;
         endcase
      end
   end

   // R11: the two status phases never overlap
   a_r11_busy_sus_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && sus));
   // R6: suspended state is only reached out of a busy phase
   a_r6_sus_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sus) |-> $past(busy));
   // R7: resume request brings busy back
   a_r7_resume_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_req && sus && !flush) |=> busy && !sus);
endmodule

// File: rtl/fcg_reset_arm.sv
module fcg_reset_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic op_valid,
   input  logic is_rsten,
   input  logic is_rst,
   output logic armed,
   output logic fire,
   output logic rst_pulse
);
   assign fire = op_valid && is_rst && armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         rst_pulse <= 1'b0;
      end else begin
         rst_pulse <= fire;
         if (op_valid) armed <= is_rsten;
      end
   end

   // R9: a reset pulse only ever follows the armed state
   a_r9_pulse_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> $past(armed));
endmodule

// File: rtl/fcg_ctrl.sv
module fcg_ctrl
   import fcg_pkg::*;
#(
   parameter int PGM_CYCLES   = 40,
   parameter int ERASE_CYCLES = 120,
   parameter int CHIP_CYCLES  = 400,
   parameter int WRSR_CYCLES  = 25,
   parameter int SUSP_LAT     = 5,
   parameter bit CHIP_ALT_EN  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_valid,
   input  logic [7:0] op_code,
   output logic       op_accept,
   output logic       op_ignore,
   output logic       wel,
   output logic       sus,
   output logic       busy,
   output logic       rst_pulse
);
   generate
      if (PGM_CYCLES < 1 || ERASE_CYCLES < 1 || CHIP_CYCLES < 1 ||
          WRSR_CYCLES < 1 || SUSP_LAT < 1) begin : g_bad_param
         $error("fcg_ctrl: all cycle counts must be at least 1");
      end
   endgenerate

   cmd_cls_e cls;
   len_sel_e lsel;
   logic     armed, fire, can_susp, done, accept_c, wel_q;

   fcg_decode #(.CHIP_ALT_EN(CHIP_ALT_EN)) u_dec (
      .code(op_code), .cls(cls), .lsel(lsel));

   always_comb begin
      case (cls)
         CL_STATUS: accept_c = 1'b1;
         CL_RSTEN:  accept_c = 1'b1;
         CL_RST:    accept_c = armed;
         CL_SUSP:   accept_c = can_susp;
         CL_RESUME: accept_c = sus && !busy;
         CL_WRITE:  accept_c = wel_q && !busy && !sus;
         default:   accept_c = !busy;
      endcase
   end

   assign op_accept = op_valid && accept_c;
   assign op_ignore = op_valid && !accept_c;

   fcg_reset_arm u_arm (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
      .is_rsten(cls == CL_RSTEN), .is_rst(cls == CL_RST),
      .armed(armed), .fire(fire), .rst_pulse(rst_pulse));

   fcg_op_timer #(
      .PGM_CYCLES(PGM_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
      .CHIP_CYCLES(CHIP_CYCLES), .WRSR_CYCLES(WRSR_CYCLES),
      .SUSP_LAT(SUSP_LAT)
   ) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .start(op_accept && cls == CL_WRITE), .len_sel(lsel),
      .susp_req(op_accept && cls == CL_SUSP),
      .resume_req(op_accept && cls == CL_RESUME),
      .flush(fire), .busy(busy), .sus(sus),
      .can_susp(can_susp), .done(done));

   always_ff @(posedge clk) begin
      if (!rst_n || fire || done) wel_q <= 1'b0;
      else if (op_accept && cls == CL_WREN) wel_q <= 1'b1;
   end
   assign wel = wel_q;

   // R3: an accepted write-class opcode found the gates open
   a_r3_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (op_accept && cls == CL_WRITE) |-> (wel && !busy && !sus));
   // R3: a write rejected for WEL=0 starts nothing
   a_r3_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && cls == CL_WRITE && !wel && !busy && !sus) |=> (!busy && !wel && !sus));
   // R4: completion clears the write-enable latch
   a_r4_done_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !wel);
   // R6: suspend is dropped unless running and not suspended
   a_r6_susp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_SUSP && (sus || !busy)) |-> !op_accept);
   // R7: resume is dropped unless suspended and idle
   a_r7_resume_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_RESUME && (!sus || busy)) |-> !op_accept);
   // R8: completed reset clears the status bits
   a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (op_accept && op_code == OP_RST) |=> (rst_pulse && !wel && !busy && !sus));
endmodule

// File: tb/fcg_ctrl_tb.sv
module fcg_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [7:0] op_code = 8'h00;
   logic       op_accept, op_ignore, wel, sus, busy, rst_pulse;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         finished = 1'b0;

   always #5 clk = ~clk;

   fcg_ctrl #(
      .PGM_CYCLES(6), .ERASE_CYCLES(10), .CHIP_CYCLES(20),
      .WRSR_CYCLES(4), .SUSP_LAT(3), .CHIP_ALT_EN(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_accept(op_accept), .op_ignore(op_ignore), .wel(wel),
      .sus(sus), .busy(busy), .rst_pulse(rst_pulse));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the sampling edge
   task automatic send(input logic [7:0] c, input logic exp_acc, input string req);
      op_code  = c;
      op_valid = 1'b1;
      #1;
      check(req, op_accept, exp_acc);
      check(req, op_ignore, !exp_acc);
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy === 1'b1 && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset_state;
      check("R1 wel", wel, 0);
      check("R1 sus", sus, 0);
      check("R1 busy", busy, 0);
      check("R1 rst_pulse", rst_pulse, 0);
   endtask

   task automatic t_write_without_wel;
      send(8'h02, 1'b0, "R3 page program without wel");
      check("R3 busy stays 0", busy, 0);
      send(8'h20, 1'b0, "R3 sector erase without wel");
      check("R3 wel stays 0", wel, 0);
      check("R3 sus stays 0", sus, 0);
   endtask

   task automatic t_program_flow;
      send(8'h06, 1'b1, "R2 write enable idle");
      check("R2 wel set", wel, 1);
      send(8'h02, 1'b1, "R3 page program with wel");
      check("R4 busy first cycle", busy, 1);
      send(8'h05, 1'b1, "R5 status read while busy");
      send(8'h38, 1'b0, "R5 other opcode while busy");
      send(8'h7A, 1'b0, "R7 resume while busy");
      wait_n(2);
      check("R4 busy last cycle", busy, 1);
      send(8'h06, 1'b0, "R2 write enable while busy");
      check("R4 busy ends", busy, 0);
      check("R4 wel cleared", wel, 0);
   endtask

   task automatic t_lengths;
      int n;
      send(8'h06, 1'b1, "R2 write enable");
      send(8'h20, 1'b1, "R3 sector erase");
      count_busy(n);
      check("R4 sector erase length", n, 10);
      check("R4 wel after erase", wel, 0);
      send(8'h06, 1'b1, "R2 write enable");
      send(8'h60, 1'b1, "R3 alt chip erase");
      count_busy(n);
      check("R4 chip erase length", n, 20);
      send(8'h06, 1'b1, "R2 write enable");
      send(8'h01, 1'b1, "R3 status write");
      count_busy(n);
      check("R4 status write length", n, 4);
      check("R4 wel after status write", wel, 0);
   endtask

   task automatic t_suspend_resume;
      int n;
      send(8'h75, 1'b0, "R6 suspend while idle");
      check("R6 sus stays 0", sus, 0);
      send(8'h7A, 1'b0, "R7 resume while not suspended");
      send(8'h06, 1'b1, "R2 write enable");
      send(8'h02, 1'b1, "R3 page program");
      send(8'h75, 1'b1, "R6 suspend while running");
      check("R6 busy during latency", busy, 1);
      check("R6 sus during latency", sus, 0);
      send(8'h75, 1'b0, "R6 second suspend while pending");
      wait_n(1);
      check("R6 busy end of latency", busy, 1);
      wait_n(1);
      check("R6 busy after latency", busy, 0);
      check("R6 sus after latency", sus, 1);
      check("R11 not both", busy & sus, 0);
      send(8'h75, 1'b0, "R6 suspend while suspended");
      check("R6 sus held", sus, 1);
      send(8'h02, 1'b0, "R3 write while suspended");
      check("R3 sus unchanged", sus, 1);
      send(8'h38, 1'b1, "R10 mode switch 38h");
      check("R10 wel kept 38h", wel, 1);
      check("R10 sus kept 38h", sus, 1);
      send(8'hFF, 1'b1, "R10 mode switch FFh");
      check("R10 wel kept FFh", wel, 1);
      check("R10 sus kept FFh", sus, 1);
      send(8'h7A, 1'b1, "R7 resume while suspended");
      check("R7 sus cleared", sus, 0);
      count_busy(n);
      check("R7 remaining length", n, 6);
      check("R7 wel after finish", wel, 0);
   endtask

   task automatic t_reset_handshake;
      send(8'h06, 1'b1, "R2 write enable");
      send(8'h66, 1'b1, "R8 reset enable");
      send(8'h99, 1'b1, "R8 reset");
      check("R8 pulse", rst_pulse, 1);
      check("R8 wel cleared", wel, 0);
      wait_n(1);
      check("R8 pulse one cycle", rst_pulse, 0);
      send(8'h06, 1'b1, "R2 write enable");
      send(8'h02, 1'b1, "R3 page program");
      send(8'h66, 1'b1, "R8 reset enable while busy");
      send(8'h99, 1'b1, "R8 reset while busy");
      check("R8 busy cleared", busy, 0);
      check("R8 sus cleared", sus, 0);
      check("R8 wel cleared mid op", wel, 0);
   endtask

   task automatic t_reset_broken;
      send(8'h06, 1'b1, "R2 write enable");
      send(8'h66, 1'b1, "R9 reset enable");
      send(8'h05, 1'b1, "R9 intervening status read");
      send(8'h99, 1'b0, "R9 reset after break");
      check("R9 no pulse", rst_pulse, 0);
      check("R9 wel kept", wel, 1);
      send(8'h99, 1'b0, "R9 lone reset");
      check("R9 wel still kept", wel, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_write_without_wel();
      t_program_flow();
      t_lengths();
      t_suspend_resume();
      t_reset_handshake();
      t_reset_broken();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1..: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule